// File: doc/BRIEF.md
# NIC Interrupt Status Controller

This block keeps the pending-cause register and the enable mask of a network interface's interrupt logic. The receive and transmit engines send it one-cycle event pulses, one wire per cause. The block records each pulse in a sticky status register, combines it with the mask, and drives a single interrupt line.

Causes fall into two groups. The urgent group raises the line as soon as a cause in it is pending. The remaining causes are coalesced: the first such pending cause starts a programmable down-counter, and the line rises only when the counter runs out while a coalesced, enabled cause is still pending.

Software reaches the block through a simple word-addressed read/write port. Reading the status word returns the pending causes and clears them. A command word can post a software interrupt and can request a device reset. The reset request also returns this block's registers to their reset values.

Top module: `nic_irq_ctrl`

Register word addresses (field positions matter to software):
- 0: configuration. Bit 2 is the interrupt enable. All other bits read as zero.
- 1: command. Write-only; reads return zero.
- 2: pending status. Reading it clears it.
- 3: enable mask.
- 4: coalescing delay, in cycles.

## Requirements
- R1: Each bit of `evt_i` sets the same bit of the status register on the clock edge that samples it. The bit stays set until it is read. Cause positions: 0 rx packet, 1 rx copy done, 2 rx queue empty, 3 rx above high mark, 4 spare, 5 tx copy done, 6 tx queue full, 7 tx below low mark, 8 software.
- R2: Only bits 8..0 (0x1FF) are valid. Writing all ones to the mask word reads back 0x1FF. Bits 31..9 of the status and mask words always read as zero.
- R3: A read of the status word (address 2) returns the pending causes and clears them. An event sampled on the same edge as the read remains pending afterwards.
- R4: After reset the mask is 0x189, the status is 0, the configuration word is 0 and the delay is DLY_RST (8 by default). `irq_o` and `dev_reset_o` are low.
- R5: Causes in the no-delay set 0x1CC (bits 2, 3, 6, 7, 8) raise `irq_o` right after the edge that captures them, provided they are enabled and interrupts are on.
- R6: An enabled coalesced cause (bits 0, 1, 4, 5) captured on edge k raises `irq_o` after edge k+D+2, where D is the delay word, and not before.
- R7: `irq_o` is low while configuration bit 2 is 0. Causes whose mask bit is 0 stay pending but never raise `irq_o`.
- R8: Writing the command word with bit 1 set makes status bit 8 pending.
- R9: Writing the command word with bit 0 set pulses `dev_reset_o` for exactly one cycle. On the same edge, mask, delay, configuration and status return to their reset values. If bit 1 is also set, the reset wins and status stays 0.
- R10: If all enabled coalesced causes are cleared before the delay expires, `irq_o` stays low. The next coalesced cause starts a fresh full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| evt_i | input | 9 | One-cycle event pulses, one per cause |
| irq_o | output | 1 | Interrupt request |
| dev_reset_o | output | 1 | One-cycle device reset request |

## Verification
The bench targets the following corner cases, each of which catches a specific design error:
- Exact delay timing: the bench measures the edge on which a coalesced cause raises the line. An off-by-one counter shows up as a rise one edge early or late.
- Event during clear: an event arrives on the same edge as a status read. A design that lets the clear win loses that event.
- Early clear of a coalesced cause: the pending cause is read away mid-delay. A design that does not rearm its timer fires a stale interrupt.
- Reset and post together: a command write sets both the reset bit and the software-interrupt bit. A wrong priority leaves a pending software cause after reset.
- Masked and reserved bits: the bench checks that masked causes stay pending without raising the line, and that reserved bits read back as zero.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int NCAUSE = 9;
  localparam logic [NCAUSE-1:0] CAUSE_VALID = 9'h1FF;
  localparam logic [NCAUSE-1:0] CAUSE_NODELAY = 9'h1CC;
  localparam logic [NCAUSE-1:0] MASK_RST = 9'h189;
  localparam int BIT_SOFT = 8;
  localparam int CFG_IEN_BIT = 2;
  localparam int CMD_RST_BIT = 0;
  localparam int CMD_SOFT_BIT = 1;
  localparam int ADR_CFG = 0;
  localparam int ADR_CMD = 1;
  localparam int ADR_STAT = 2;
  localparam int ADR_MASK = 3;
  localparam int ADR_DLY = 4;

  function automatic logic [NCAUSE-1:0] f_next_status(
    input logic [NCAUSE-1:0] cur, input logic clr, input logic [NCAUSE-1:0] evt);
    return (clr ? '0 : cur) | (evt & CAUSE_VALID);
  endfunction

  function automatic logic f_imm_hit(input logic [NCAUSE-1:0] st,
                                     input logic [NCAUSE-1:0] msk);
    return |(st & msk & CAUSE_NODELAY);
  endfunction

  function automatic logic f_coal_hit(input logic [NCAUSE-1:0] st,
                                      input logic [NCAUSE-1:0] msk);
    return |(st & msk & ~CAUSE_NODELAY);
  endfunction
endpackage

// File: rtl/nic_irq_regs.sv
module nic_irq_regs
  import nic_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int DLY_W = 16,
  parameter int unsigned DLY_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NCAUSE-1:0] status_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCAUSE-1:0] mask_q,
  output logic              ien_q,
  output logic [DLY_W-1:0]  dly_q,
  output logic              stat_clr,
  output logic              soft_post,
  output logic              sw_rst,
  output logic              dev_reset_q
);
  localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(DLY_RST);

  logic wr_cfg, wr_cmd, wr_mask, wr_dly;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wbits;

  assign wr_cfg  = reg_wr && (reg_addr == ADDR_W'(ADR_CFG));
  assign wr_cmd  = reg_wr && (reg_addr == ADDR_W'(ADR_CMD));
  assign wr_mask = reg_wr && (reg_addr == ADDR_W'(ADR_MASK));
  assign wr_dly  = reg_wr && (reg_addr == ADDR_W'(ADR_DLY));
  assign stat_clr  = reg_rd && (reg_addr == ADDR_W'(ADR_STAT));
  assign sw_rst    = wr_cmd && reg_wdata[CMD_RST_BIT];
  assign soft_post = wr_cmd && reg_wdata[CMD_SOFT_BIT];
  assign unused_wbits = ^reg_wdata;

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(ADR_CFG))  rd_mux = DATA_W'({ien_q, 2'b00});
    if (reg_addr == ADDR_W'(ADR_STAT)) rd_mux = DATA_W'(status_q);
    if (reg_addr == ADDR_W'(ADR_MASK)) rd_mux = DATA_W'(mask_q);
    if (reg_addr == ADDR_W'(ADR_DLY))  rd_mux = DATA_W'(dly_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= MASK_RST;
      ien_q       <= 1'b0;
      dly_q       <= DLY_INIT;
      dev_reset_q <= 1'b0;
      reg_rdata   <= '0;
    end else begin
      dev_reset_q <= sw_rst;
      if (sw_rst) begin
        mask_q <= MASK_RST;
        ien_q  <= 1'b0;
        dly_q  <= DLY_INIT;
      end else begin
        if (wr_cfg)  ien_q  <= reg_wdata[CFG_IEN_BIT];
        if (wr_mask) mask_q <= reg_wdata[NCAUSE-1:0] & CAUSE_VALID;
        if (wr_dly)  dly_q  <= reg_wdata[DLY_W-1:0];
      end
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              stat_clr,
  input  logic              soft_post,
  input  logic [NCAUSE-1:0] evt_i,
  output logic [NCAUSE-1:0] status_q
);
  logic [NCAUSE-1:0] evt_all;

  always_comb begin
    evt_all = evt_i;
    if (soft_post) evt_all[BIT_SOFT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_q <= '0;
    else if (sw_rst) status_q <= '0;
    else             status_q <= f_next_status(status_q, stat_clr, evt_all);
  end
endmodule

// File: rtl/nic_irq_coalesce.sv
module nic_irq_coalesce #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             coal_hit,
  input  logic [DLY_W-1:0] dly_q,
  output logic             fired_q,
  output logic             run_q
);
  logic [DLY_W-1:0] cnt_q;
  logic cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; fired_q <= 1'b0; cnt_q <= '0;
    end else if (sw_rst || !coal_hit) begin
      run_q <= 1'b0; fired_q <= 1'b0; cnt_q <= '0;
    end else if (!run_q && !fired_q) begin
      run_q <= 1'b1;
      cnt_q <= dly_q;
    end else if (run_q) begin
      if (cnt_zero) begin
        run_q   <= 1'b0;
        fired_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int DLY_W = 16,
  parameter int unsigned DLY_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [8:0]        evt_i,
  output logic              irq_o,
  output logic              dev_reset_o
);
  logic [NCAUSE-1:0] status_q, mask_q;
  logic [DLY_W-1:0]  dly_q;
  logic ien_q, stat_clr, soft_post, sw_rst;
  logic imm_hit, coal_hit, fired_q, run_q;

  nic_irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W), .DLY_RST(DLY_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status_q(status_q),
    .reg_rdata(reg_rdata), .mask_q(mask_q), .ien_q(ien_q), .dly_q(dly_q),
    .stat_clr(stat_clr), .soft_post(soft_post), .sw_rst(sw_rst),
    .dev_reset_q(dev_reset_o));

  nic_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .stat_clr(stat_clr),
    .soft_post(soft_post), .evt_i(evt_i), .status_q(status_q));

  assign imm_hit  = f_imm_hit(status_q, mask_q);
  assign coal_hit = f_coal_hit(status_q, mask_q);

  nic_irq_coalesce #(.DLY_W(DLY_W)) u_coal (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .coal_hit(coal_hit),
    .dly_q(dly_q), .fired_q(fired_q), .run_q(run_q));

  assign irq_o = ien_q && (imm_hit || (fired_q && coal_hit));
endmodule

// File: rtl/nic_irq_chk.sv
module nic_irq_chk
  import nic_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [8:0]        evt_i,
  input logic              irq_o,
  input logic              dev_reset_o,
  input logic [NCAUSE-1:0] status_q,
  input logic [NCAUSE-1:0] mask_q,
  input logic              ien_q
);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == ADDR_W'(ADR_STAT)) |=> (status_q == $past(evt_i)));

  p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == ADDR_W'(ADR_STAT) || reg_addr == ADDR_W'(ADR_MASK)))
      |=> (reg_rdata[DATA_W-1:NCAUSE] == '0));

  p_urgent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q && |(status_q & mask_q & CAUSE_NODELAY)) |-> irq_o);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> !irq_o);

  p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(status_q & mask_q));

  p_soft_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(ADR_CMD) && reg_wdata[CMD_SOFT_BIT] && !reg_wdata[CMD_RST_BIT])
      |=> status_q[BIT_SOFT]);

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_o |=> !dev_reset_o);

  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_o |-> (mask_q == MASK_RST && status_q == '0 && !ien_q));
endmodule

bind nic_irq_ctrl nic_irq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .evt_i(evt_i), .irq_o(irq_o), .dev_reset_o(dev_reset_o),
  .status_q(status_q), .mask_q(mask_q), .ien_q(ien_q));

// File: tb/test_nic_irq_ctrl.sv
module test_nic_irq_ctrl;
  localparam int DW = 32;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [8:0] evt = '0;
  logic irq, dev_reset;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  nic_irq_ctrl i_nic_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_i(evt), .irq_o(irq), .dev_reset_o(dev_reset));

  // {mask, event, expected status read, expected irq right after capture}
  localparam logic [27:0] VEC [0:7] = '{
    {9'h1FF, 9'h001, 9'h001, 1'b0},
    {9'h1FF, 9'h004, 9'h004, 1'b1},
    {9'h000, 9'h1CC, 9'h1CC, 1'b0},
    {9'h100, 9'h100, 9'h100, 1'b1},
    {9'h080, 9'h040, 9'h040, 1'b0},
    {9'h1FF, 9'h033, 9'h033, 1'b0},
    {9'h1FF, 9'h1FF, 9'h1FF, 1'b1},
    {9'h008, 9'h008, 9'h008, 1'b1}};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = AW'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic pulse(input logic [8:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int rise;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    check("R4 irq", 32'(irq), 0);
    check("R4 dev_reset", 32'(dev_reset), 0);
    rd(3, v); check("R4 mask", v, 32'h189);
    rd(2, v); check("R4 status", v, 0);
    rd(0, v); check("R4 config", v, 0);
    rd(4, v); check("R4 delay", v, 8);

    // R2 reserved bits
    wr(3, 32'hFFFF_FFFF);
    rd(3, v); check("R2 mask valid bits", v, 32'h1FF);

    // vector table: R1 R5 R7 with a long delay so coalesced causes stay quiet
    wr(4, 1000);
    wr(0, 32'h4);
    rd(0, v); check("R7 config enable bit", v, 32'h4);
    foreach (VEC[i]) begin
      wr(3, 32'(VEC[i][27:19]));
      pulse(VEC[i][18:10]);
      check($sformatf("R5 irq vec%0d", i), 32'(irq), 32'(VEC[i][0]));
      rd(2, v);
      check($sformatf("R1 status vec%0d", i), v, 32'(VEC[i][9:1]));
      check($sformatf("R3 irq after clear vec%0d", i), 32'(irq), 0);
    end

    // R3 event on the same edge as the read-clear
    wr(3, 32'h1FF);
    pulse(9'h004);
    reg_rd = 1'b1; reg_addr = AW'(2); evt = 9'h008;
    @(negedge clk);
    reg_rd = 1'b0; evt = '0;
    check("R3 read returns old", reg_rdata, 32'h004);
    rd(2, v); check("R3 simultaneous event kept", v, 32'h008);

    // R6 coalescing delay: expected rise D+2 edges after capture
    wr(4, 5);
    pulse(9'h001);
    rise = 0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (irq && rise == 0) rise = n;
    end
    check("R6 coalesce rise edge", 32'(rise), 7);
    rd(2, v); check("R6 status", v, 32'h001);

    // R10 clear before expiry
    pulse(9'h002);
    repeat (3) @(negedge clk);
    rd(2, v); check("R10 status mid delay", v, 32'h002);
    rise = 0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (irq) rise = 1;
    end
    check("R10 no stale irq", 32'(rise), 0);
    pulse(9'h020);
    rise = 0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (irq && rise == 0) rise = n;
    end
    check("R10 fresh full delay", 32'(rise), 7);
    rd(2, v);

    // R7 global enable gating
    wr(0, 0);
    pulse(9'h008);
    check("R7 gated off", 32'(irq), 0);
    wr(0, 32'h4);
    check("R7 enabled with pending", 32'(irq), 1);
    rd(2, v); check("R7 pending kept", v, 32'h008);

    // R8 software interrupt
    wr(1, 32'h2);
    check("R8 soft irq", 32'(irq), 1);
    rd(2, v); check("R8 soft status", v, 32'h100);
    rd(1, v); check("R8 command reads zero", v, 0);

    // R9 reset command, with soft post in the same write
    pulse(9'h008);
    wr(1, 32'h3);
    check("R9 reset pulse", 32'(dev_reset), 1);
    check("R9 irq after reset", 32'(irq), 0);
    @(negedge clk);
    check("R9 pulse one cycle", 32'(dev_reset), 0);
    rd(2, v); check("R9 status cleared, reset wins", v, 0);
    rd(3, v); check("R9 mask restored", v, 32'h189);
    rd(4, v); check("R9 delay restored", v, 8);
    rd(0, v); check("R9 config restored", v, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule